// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog

This block is a single interval timer driven by the bus clock and programmed through a small register bus with write and read strobes. A count register holds a one-based clock divisor and a terminal count. The timer counts divided ticks from zero up to the terminal count. Each time it gets there it either raises a timeout flag, which can drive an interrupt, or fires a watchdog reset. It then reloads and runs again (continuous) or halts (one-shot).

The same counter serves as a watchdog. Writing the mode register with both the watchdog bit and the run bit set locks the block into watchdog operation. Software keeps the system alive by writing the key byte 0xA5 into the top byte of the mode register, which restarts the period. If the period runs out first, a reset output goes high and stays high until system reset. While the lock holds, the block refuses every attempt to reconfigure or stop the timer.

Top module: `ivt_top`

## Requirements
- R1: After reset, every register reads zero, the timer is stopped, and both `irqOut` and `wdtReset` are low.
- R2: Register map: address 0 is mode, address 1 is count, address 2 is status, and address 3 reads zero. The count register keeps the divisor in bits 31:16 and the terminal count in bits 15:0, and reads back what was written. A terminal count of 0 acts as 65536.
- R3: Writing mode with bit 12 set, while the timer is stopped, starts a new period. The status flag rises D*T clock edges after that write edge, where D is the divisor, T is the terminal count, and a divisor of 0 gives D = 65536.
- R4: With bit 10 clear (one-shot), an expiry sets the flag once and clears mode bit 12 in hardware. No further expiry follows.
- R5: With mode bit 10 set (continuous), the timer reloads at each expiry and sets status bit 0 again every period.
- R6: Writing a 1 to status bit 0 clears the flag, and writing a 0 leaves it unchanged. `irqOut` is the flag gated by mode bit 8.
- R7: A count register write made while the timer runs does not change the current period. It takes effect at the next reload.
- R8: Writing mode with bit 12 clear stops the timer, and no expiry follows.
- R9: A mode write with bits 15 and 12 both set enters watchdog operation, which reads back as 0x9000. A watchdog expiry raises `wdtReset`, which stays high until reset, and does not set the status flag.
- R10: A mode write whose bits 31:24 equal 0xA5 never changes the mode fields. In watchdog operation it restarts the period from the current count register.
- R11: In watchdog operation, other mode writes and all count writes are ignored. Watchdog operation lasts until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe, read data is combinational |
| busAddr | input | 2 | Register address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, zero when not reading |
| irqOut | output | 1 | Timeout interrupt |
| wdtReset | output | 1 | Sticky watchdog reset request |

## Verification
On every cycle the assertions check the following:
- The prescale and count state stays inside the active divisor and terminal count.
- A restart clears both counters.
- Every timer expiry lands in the flag, and every watchdog expiry lands in the reset output.
- One-shot mode disarms after its expiry.
- The lock, the reset output and the locked count value never change once set.

Only the bench scenarios can show the following:
- The exact period length for each divisor and terminal count, including both 65536 cases.
- That a count write made while running waits for the next reload.
- That a service write moves the watchdog deadline.
- That rejected writes leave the readback unchanged.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int BIT_IRQ  = 8;
  localparam int BIT_CONT = 10;
  localparam int BIT_EN   = 12;
  localparam int BIT_WDT  = 15;
  localparam int KEY_W    = 8;
  localparam logic [KEY_W-1:0] SERVICE_KEY = 8'hA5;

  typedef struct packed {
    logic load;  // restart: clear counters, take count register as active
    logic run;   // counting allowed this cycle
  } ivtStrobe_t;
endpackage

// File: rtl/ivt_count.sv
module ivt_count
  import ivt_pkg::*;
#(
  parameter int PS_W  = 16,
  parameter int CNT_W = 16,
  localparam int REG_W = PS_W + CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ivtStrobe_t       strb,
  input  logic [REG_W-1:0] countIn,
  output logic             expire
);
  logic [PS_W-1:0]  activePs;
  logic [CNT_W-1:0] activeTerm;
  logic [PS_W-1:0]  psCnt;
  logic [CNT_W-1:0] cnt;
  logic [PS_W-1:0]  divM1;
  logic [CNT_W-1:0] lastCnt;
  logic             tick;
  logic             expireRaw;

  // One-based divisor and terminal count; zero wraps to the full range.
  assign divM1     = activePs - PS_W'(1);
  assign lastCnt   = activeTerm - CNT_W'(1);
  assign tick      = strb.run && (psCnt == divM1);
  assign expireRaw = tick && (cnt == lastCnt);
  assign expire    = expireRaw && !strb.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activePs   <= '0;
      activeTerm <= '0;
      psCnt      <= '0;
      cnt        <= '0;
    end else if (strb.load) begin
      psCnt      <= '0;
      cnt        <= '0;
      activePs   <= countIn[REG_W-1:CNT_W];
      activeTerm <= countIn[CNT_W-1:0];
    end else if (strb.run) begin
      if (tick) begin
        psCnt <= '0;
        if (expireRaw) begin
          cnt        <= '0;
          activePs   <= countIn[REG_W-1:CNT_W];
          activeTerm <= countIn[CNT_W-1:0];
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        psCnt <= psCnt + PS_W'(1);
      end
    end
  end

  // R3: prescale state never passes the active divisor
  p_ps_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    psCnt <= divM1);
  // R2: counter never passes the active terminal count
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt);
  // R10: a restart leaves both counters at zero
  p_load_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (psCnt == '0 && cnt == '0));
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int PS_W  = 16,
  parameter int CNT_W = 16,
  localparam int REG_W = PS_W + CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             expire,
  output logic [REG_W-1:0] countReg,
  output ivtStrobe_t       strb,
  output logic             irqOut,
  output logic             wdtReset
);
  logic modeEn, modeCont, modeIrq, wdtActive, flagQ, wdtResetQ;
  logic wrMode, wrCount, wrStatus, isService;
  logic enterWdt, startTimer, serviceHit;

  assign wrMode    = wrEn && (addr == ADDR_MODE);
  assign wrCount   = wrEn && (addr == ADDR_COUNT);
  assign wrStatus  = wrEn && (addr == ADDR_STATUS);
  assign isService = (wrData[REG_W-1 -: KEY_W] == SERVICE_KEY);

  assign enterWdt   = wrMode && !isService && !wdtActive
                      && wrData[BIT_WDT] && wrData[BIT_EN];
  assign startTimer = wrMode && !isService && !wdtActive && !enterWdt
                      && wrData[BIT_EN] && !modeEn;
  assign serviceHit = wrMode && isService && wdtActive;

  assign strb.load = enterWdt || startTimer || serviceHit;
  assign strb.run  = modeEn && !wdtResetQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn    <= 1'b0;
      modeCont  <= 1'b0;
      modeIrq   <= 1'b0;
      wdtActive <= 1'b0;
      flagQ     <= 1'b0;
      wdtResetQ <= 1'b0;
      countReg  <= '0;
    end else begin
      if (wrStatus && wrData[0]) flagQ <= 1'b0;
      if (expire) begin
        if (wdtActive) begin
          wdtResetQ <= 1'b1;
        end else begin
          flagQ <= 1'b1;
          if (!modeCont) modeEn <= 1'b0;
        end
      end
      if (wrMode && !isService && !wdtActive) begin
        if (enterWdt) begin
          wdtActive <= 1'b1;
          modeEn    <= 1'b1;
          modeCont  <= 1'b0;
          modeIrq   <= 1'b0;
        end else begin
          modeEn   <= wrData[BIT_EN];
          modeCont <= wrData[BIT_CONT];
          modeIrq  <= wrData[BIT_IRQ];
        end
      end
      if (wrCount && !wdtActive) countReg <= wrData;
    end
  end

  logic [REG_W-1:0] modeView;
  always_comb begin
    modeView           = '0;
    modeView[BIT_WDT]  = wdtActive;
    modeView[BIT_EN]   = modeEn;
    modeView[BIT_CONT] = modeCont;
    modeView[BIT_IRQ]  = modeIrq;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        ADDR_MODE:   rdData = modeView;
        ADDR_COUNT:  rdData = countReg;
        ADDR_STATUS: rdData = {{(REG_W-1){1'b0}}, flagQ};
        default:     rdData = '0;
      endcase
    end
  end

  assign irqOut   = flagQ && modeIrq;
  assign wdtReset = wdtResetQ;

  // R9: reset request is sticky
  p_wdt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdtResetQ |=> wdtResetQ);
  // R9: a watchdog expiry reaches the reset output
  p_wdt_fire_r9: assert property (@(posedge clk) disable iff (!rstN)
    (expire && wdtActive) |=> wdtResetQ);
  // R9: watchdog operation never raises the timer flag
  p_wdt_no_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wdtActive && !flagQ) |=> !flagQ);
  // R11: lock holds until reset
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    wdtActive |=> wdtActive);
  // R11: count register frozen while locked
  p_lock_count_r11: assert property (@(posedge clk) disable iff (!rstN)
    wdtActive |=> $stable(countReg));
  // R5: a timer expiry always sets the flag
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !wdtActive) |=> flagQ);
  // R4: one-shot disarms after expiry
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !modeCont && !wdtActive && !wrMode) |=> !modeEn);
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int PS_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqOut,
  output logic        wdtReset
);
  localparam int REG_W = PS_W + CNT_W;

  ivtStrobe_t       strb;
  logic [REG_W-1:0] countReg;
  logic             expire;

  ivt_ctrl #(.PS_W(PS_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn),
    .addr(busAddr), .wrData(busWrData), .rdData(busRdData),
    .expire(expire), .countReg(countReg), .strb(strb),
    .irqOut(irqOut), .wdtReset(wdtReset)
  );

  ivt_count #(.PS_W(PS_W), .CNT_W(CNT_W)) count_i (
    .clk(clk), .rstN(rstN), .strb(strb), .countIn(countReg),
    .expire(expire)
  );
endmodule

// File: tb/ivt_top_tb_top.sv
module ivt_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, wdtReset;

  int unsigned cyc = 0;
  int unsigned wrCyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ivt_top dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned periodOf(logic [31:0] cnt);
    int unsigned d, t;
    d = (cnt[31:16] == 0) ? 65536 : cnt[31:16];
    t = (cnt[15:0] == 0) ? 65536 : cnt[15:0];
    return d * t;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    wrCyc = cyc;
  endtask

  task automatic busRead(logic [1:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    #1;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic waitCyc(int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expectExpiry(string tag, int unsigned base, int unsigned p);
    logic [31:0] v;
    waitCyc(base + p - 1);
    busRead(2'd2, v); check({tag, " flag before period"}, v, 32'd0);
    waitCyc(base + p);
    busRead(2'd2, v); check({tag, " flag at period"}, v, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned st;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd0, v); check("R1 mode", v, 0);
    busRead(2'd1, v); check("R1 count", v, 0);
    busRead(2'd2, v); check("R1 status", v, 0);
    check("R1 irqOut", {31'd0, irqOut}, 0);
    check("R1 wdtReset", {31'd0, wdtReset}, 0);

    // R2 map and readback
    busWrite(2'd1, 32'h1234_5678);
    busRead(2'd1, v); check("R2 count readback", v, 32'h1234_5678);
    busRead(2'd3, v); check("R2 addr3 zero", v, 0);

    // R10 key write in timer mode leaves fields
    busWrite(2'd0, 32'hA500_1500);
    busRead(2'd0, v); check("R10 key write no fields", v, 0);

    // R3 divisor 0 means 65536
    busWrite(2'd1, 32'h0000_0001);
    busWrite(2'd0, 32'h0000_1000);
    expectExpiry("R3 divisor zero", wrCyc, 65536);
    busWrite(2'd2, 32'h1);

    // R2 terminal 0 means 65536
    busWrite(2'd1, 32'h0001_0000);
    busWrite(2'd0, 32'h0000_1000);
    expectExpiry("R2 terminal zero", wrCyc, 65536);
    busWrite(2'd2, 32'h1);

    // R4 one-shot
    busWrite(2'd1, 32'h0002_0003);
    busWrite(2'd0, 32'h0000_1100);
    st = wrCyc;
    expectExpiry("R4 one-shot", st, 6);
    busRead(2'd0, v); check("R4 en cleared", v, 32'h0000_0100);
    // R6 flag and irq
    check("R6 irq high", {31'd0, irqOut}, 1);
    busWrite(2'd2, 32'h0);
    busRead(2'd2, v); check("R6 write zero keeps flag", v, 1);
    busWrite(2'd0, 32'h0);
    check("R6 irq masked", {31'd0, irqOut}, 0);
    busWrite(2'd2, 32'h1);
    busRead(2'd2, v); check("R6 w1c clears", v, 0);
    waitCyc(cyc + 20);
    busRead(2'd2, v); check("R4 no second expiry", v, 0);

    // R7 count write applies at next reload (continuous, R5)
    busWrite(2'd1, 32'h0001_000A);
    busWrite(2'd0, 32'h0000_1400);
    st = wrCyc;
    busWrite(2'd1, 32'h0001_0004);
    expectExpiry("R7 old period", st, 10);
    busWrite(2'd2, 32'h1);
    expectExpiry("R7 new period R5", st + 10, 4);
    busWrite(2'd0, 32'h0);
    busWrite(2'd2, 32'h1);

    // R8 stop
    busWrite(2'd1, 32'h0001_0008);
    busWrite(2'd0, 32'h0000_1000);
    st = wrCyc;
    busWrite(2'd0, 32'h0);
    waitCyc(st + 25);
    busRead(2'd2, v); check("R8 stopped no flag", v, 0);
    busRead(2'd0, v); check("R8 mode off", v, 0);

    // Random periods, one-shot and continuous
    for (int i = 0; i < 24; i++) begin
      logic [31:0] cv, mv;
      bit cont, irqE;
      int unsigned p;
      cv = {16'(2 + $urandom_range(2)), 16'(2 + $urandom_range(4))};
      cont = 1'($urandom_range(1));
      irqE = 1'($urandom_range(1));
      mv = 32'h1000 | (32'(cont) << 10) | (32'(irqE) << 8);
      p = periodOf(cv);
      busWrite(2'd1, cv);
      busWrite(2'd0, mv);
      st = wrCyc;
      expectExpiry(cont ? "R5 random" : "R3 random", st, p);
      check("R6 random irq", {31'd0, irqOut}, {31'd0, irqE});
      if (cont) begin
        busWrite(2'd2, 32'h1);
        expectExpiry("R5 repeat", st + p, p);
      end else begin
        busRead(2'd0, v); check("R4 random disarm", v, mv & ~32'h1000);
      end
      busWrite(2'd0, 32'h0);
      busWrite(2'd2, 32'h1);
    end

    // Watchdog: R9, R10, R11
    busWrite(2'd1, 32'h0001_0014);
    busWrite(2'd0, 32'h0000_9000);
    st = wrCyc;
    busRead(2'd0, v); check("R9 enter readback", v, 32'h0000_9000);
    busWrite(2'd1, 32'h0001_0005);
    busRead(2'd1, v); check("R11 count write ignored", v, 32'h0001_0014);
    busWrite(2'd0, 32'h0000_0000);
    busRead(2'd0, v); check("R11 stop ignored", v, 32'h0000_9000);
    waitCyc(st + 12);
    busWrite(2'd0, 32'hA500_0000);
    begin
      int unsigned svc;
      svc = wrCyc;
      waitCyc(st + 20);
      check("R10 service moved deadline", {31'd0, wdtReset}, 0);
      waitCyc(svc + 19);
      check("R10 before new deadline", {31'd0, wdtReset}, 0);
      waitCyc(svc + 20);
      check("R9 reset fired", {31'd0, wdtReset}, 1);
    end
    busRead(2'd2, v); check("R9 no flag", v, 0);
    busRead(2'd0, v); check("R10 fields kept", v, 32'h0000_9000);
    waitCyc(cyc + 10);
    check("R9 reset sticky", {31'd0, wdtReset}, 1);
    check("R9 no irq", {31'd0, irqOut}, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule